// File: doc/BRIEF.md
# Sparse Address Readout with Row Skip

This block drains a binary disparity array one row at a time. A pulse on the start input launches a frame. The block then walks through every row in ascending order, drives the row index out to the array, and receives the row's activity bits and polarity bits back. Each row first gets a fixed settle interval, modelled in clock cycles. After that interval the block either scans all columns in ascending order or, when row skipping is enabled and the row holds no active pixel, closes the row straight away.

Every active pixel produces one output word: the column index in the low bits, with the pixel's polarity bit above it. The word is qualified by a write strobe that is low for one cycle. An end-of-row pulse closes every row and an end-of-frame pulse closes the frame. The word stream is therefore the same in both modes, and only the frame duration differs. Normal mode gives every row a constant time. Skip mode makes the readout time scale with the number of occupied rows, so a downstream processor can go back to sleep sooner.

Top module: `sparse_row_readout`

## Requirements
- R1: While reset is held and afterwards until a start is accepted: wr_n_o is 1, eor_o, eof_o and busy_o are 0, and row_sel_o is 0.
- R2: An accepted frame addresses the rows 0, 1, ..., ROWS-1 in that order on row_sel_o. Row 0 is driven in the first cycle after start is sampled, and each change of row_sel_o is an increment of one.
- R3: For every active pixel (row_act_i bit c = 1) of the addressed row, wr_n_o is low for exactly one cycle with word_o = {row_pol_i[c], c}. Bit 6 is the polarity and bits 5:0 are the column. Words within a row come in ascending column order.
- R4: Each frame produces exactly ROWS end-of-row pulses, one per row. A row's end-of-row pulse is never followed by a word of that same row. It may share its cycle with the word of the last column.
- R5: eof_o pulses for exactly one cycle, in the cycle directly after the final end-of-row pulse.
- R6: In normal mode (skip_en_i = 0 at start) every row lasts SETTLE + COLS cycles, whatever it holds.
- R7: In skip mode an empty row lasts SETTLE + 1 cycles and an occupied row SETTLE + COLS cycles. With the sum S of row durations, eof_o first appears S + 1 cycles after the cycle in which start was sampled.
- R8: For the same array content, the sequence of words, end-of-row and end-of-frame markers is identical in both modes.
- R9: skip_en_i is sampled only together with an accepted start. Changing it during a frame does not alter that frame's timing.
- R10: A start pulse while a frame is in progress is ignored. The frame timing and stream are unchanged, and no second frame follows.
- R11: busy_o is 1 from the cycle after start is sampled until eof_o is shown. It is 0 in the eof_o cycle and afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Frame launch request, sampled while idle |
| skip_en_i | input | 1 | 1 selects row skipping, latched at start |
| row_act_i | input | COLS | Activity bits of the addressed row |
| row_pol_i | input | COLS | Polarity bits of the addressed row |
| row_sel_o | output | clog2(ROWS) | Index of the addressed row |
| word_o | output | clog2(COLS)+1 | {polarity, column} of the delivered pixel |
| wr_n_o | output | 1 | Active-low word strobe, one cycle per word |
| eor_o | output | 1 | End-of-row pulse |
| eof_o | output | 1 | End-of-frame pulse |
| busy_o | output | 1 | Frame in progress |

## Verification
The hardest case to reach is a row whose last column is active. Its word and its end-of-row pulse then leave in the same cycle, and the next row is addressed at that edge. A mistake there shows up as a dropped or misattributed word only when a skipped row follows. Directed frames therefore place active pixels in columns 0 and 63 next to empty rows. Random sparse frames are read in both modes, and each stream is compared against one built from the array contents. A frame-length count derived from the occupancy of each row pins down the per-row timing in both modes.

// File: rtl/sparse_row_readout_pkg.sv
package sparse_row_readout_pkg;

   typedef enum logic [2:0] {
      RD_IDLE   = 3'd0,
      RD_SETTLE = 3'd1,
      RD_SCAN   = 3'd2,
      RD_SKIP   = 3'd3,
      RD_FIN    = 3'd4
   } rd_state_e;

endpackage

// File: rtl/sparse_row_occ.sv
module sparse_row_occ #(
   parameter int WIDTH    = 64,
   parameter int SEG      = 8,
   parameter bit USE_TREE = 1'b1
) (
   input  logic [WIDTH-1:0] bits_i,
   output logic             any_o
);
   localparam int NSEG = WIDTH / SEG;

   generate
      if (USE_TREE) begin : g_tree
         if ((WIDTH % SEG) != 0 || SEG < 1) begin : g_bad
            $error("sparse_row_occ: WIDTH must be a multiple of SEG");
         end
         logic [NSEG-1:0] seg_any;
         for (genvar s = 0; s < NSEG; s++) begin : g_seg
            assign seg_any[s] = |bits_i[s*SEG +: SEG];
         end
         assign any_o = |seg_any;
      end else begin : g_flat
         assign any_o = |bits_i;
      end
   endgenerate

endmodule

// File: rtl/sparse_row_seq.sv
module sparse_row_seq
   import sparse_row_readout_pkg::*;
#(
   parameter int ROWS   = 64,
   parameter int COLS   = 64,
   parameter int SETTLE = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     start_i,
   input  logic                     skip_en_i,
   input  logic                     occ_i,
   output rd_state_e                state_o,
   output logic [$clog2(ROWS)-1:0]  row_o,
   output logic [$clog2(COLS)-1:0]  col_o
);
   localparam int ROW_AW = $clog2(ROWS);
   localparam int COL_AW = $clog2(COLS);
   localparam int SET_W  = $clog2(SETTLE + 1);
   localparam logic [ROW_AW-1:0] LAST_ROW = ROW_AW'(ROWS - 1);
   localparam logic [COL_AW-1:0] LAST_COL = COL_AW'(COLS - 1);
   localparam logic [SET_W-1:0]  LAST_SET = SET_W'(SETTLE - 1);

   rd_state_e         state_q;
   logic [ROW_AW-1:0] row_q;
   logic [COL_AW-1:0] col_q;
   logic [SET_W-1:0]  set_q;
   logic              skip_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= RD_IDLE;
         row_q   <= '0;
         col_q   <= '0;
         set_q   <= '0;
         skip_q  <= 1'b0;
      end else begin
         case (state_q)
            RD_IDLE: begin
               if (start_i) begin
                  skip_q  <= skip_en_i;
                  row_q   <= '0;
                  col_q   <= '0;
                  set_q   <= '0;
                  state_q <= RD_SETTLE;
               end
            end
            RD_SETTLE: begin
               if (set_q == LAST_SET) begin
                  set_q   <= '0;
                  state_q <= (skip_q && !occ_i) ? RD_SKIP : RD_SCAN;
               end else begin
                  set_q <= set_q + 1'b1;
               end
            end
            RD_SCAN, RD_SKIP: begin
               if (state_q == RD_SCAN && col_q != LAST_COL) begin
                  col_q <= col_q + 1'b1;
               end else begin
                  col_q <= '0;
                  if (row_q == LAST_ROW) begin
                     state_q <= RD_FIN;
                  end else begin
                     row_q   <= row_q + 1'b1;
                     state_q <= RD_SETTLE;
                  end
               end
            end
            RD_FIN:  state_q <= RD_IDLE;
            default: state_q <= RD_IDLE;
         endcase
      end
   end

   assign state_o = state_q;
   assign row_o   = row_q;
   assign col_o   = col_q;

   AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != RD_IDLE && $past(state_q) != RD_IDLE) |-> $stable(skip_q)); // R9
   AST_ROW_HOLD_SCAN: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == RD_SCAN && col_q != LAST_COL) |=> $stable(row_q)); // R2
   AST_COL_ZERO_SETTLE: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == RD_SETTLE) |-> (col_q == '0)); // R3
   AST_SKIP_ONLY_MODE: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == RD_SKIP) |-> skip_q); // R7
   AST_FIN_LAST_ROW: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == RD_FIN) |-> (row_q == LAST_ROW)); // R4

endmodule

// File: rtl/sparse_row_emit.sv
module sparse_row_emit
   import sparse_row_readout_pkg::*;
#(
   parameter int COLS = 64
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  rd_state_e                state_i,
   input  logic [$clog2(COLS)-1:0]  col_i,
   input  logic                     act_i,
   input  logic                     pol_i,
   output logic [$clog2(COLS):0]    word_o,
   output logic                     wr_n_o,
   output logic                     eor_o,
   output logic                     eof_o
);
   localparam int COL_AW = $clog2(COLS);
   localparam logic [COL_AW-1:0] LAST_COL = COL_AW'(COLS - 1);

   logic [COL_AW:0] word_q;
   logic            wr_n_q, eor_q, eof_q;
   logic            deliver;

   assign deliver = (state_i == RD_SCAN) && act_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_q <= '0;
         wr_n_q <= 1'b1;
         eor_q  <= 1'b0;
         eof_q  <= 1'b0;
      end else begin
         wr_n_q <= !deliver;
         if (deliver) word_q <= {pol_i, col_i};
         eor_q  <= ((state_i == RD_SCAN) && (col_i == LAST_COL)) || (state_i == RD_SKIP);
         eof_q  <= (state_i == RD_FIN);
      end
   end

   assign word_o = word_q;
   assign wr_n_o = wr_n_q;
   assign eor_o  = eor_q;
   assign eof_o  = eof_q;

   AST_EOF_AFTER_EOR: assert property (@(posedge clk) disable iff (!rst_n)
      eof_q |-> $past(eor_q)); // R5
   AST_EOF_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      eof_q |=> !eof_q); // R5
   AST_NO_WORD_AT_EOF: assert property (@(posedge clk) disable iff (!rst_n)
      eof_q |-> (wr_n_q && !eor_q)); // R4

endmodule

// File: rtl/sparse_row_readout.sv
module sparse_row_readout
   import sparse_row_readout_pkg::*;
#(
   parameter int ROWS     = 64,
   parameter int COLS     = 64,
   parameter int SETTLE   = 4,
   parameter int OCC_SEG  = 8,
   parameter bit OCC_TREE = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     start_i,
   input  logic                     skip_en_i,
   input  logic [COLS-1:0]          row_act_i,
   input  logic [COLS-1:0]          row_pol_i,
   output logic [$clog2(ROWS)-1:0]  row_sel_o,
   output logic [$clog2(COLS):0]    word_o,
   output logic                     wr_n_o,
   output logic                     eor_o,
   output logic                     eof_o,
   output logic                     busy_o
);
   localparam int ROW_AW = $clog2(ROWS);
   localparam int COL_AW = $clog2(COLS);

   generate
      if (ROWS < 2 || COLS < 2) begin : g_bad_dim
         $error("sparse_row_readout: ROWS and COLS must be at least 2");
      end
      if (SETTLE < 1) begin : g_bad_settle
         $error("sparse_row_readout: SETTLE must be at least 1");
      end
   endgenerate

   rd_state_e         state;
   logic [ROW_AW-1:0] row;
   logic [COL_AW-1:0] col;
   logic              occ;

   sparse_row_occ #(.WIDTH(COLS), .SEG(OCC_SEG), .USE_TREE(OCC_TREE)) u_occ (
      .bits_i (row_act_i),
      .any_o  (occ)
   );

   sparse_row_seq #(.ROWS(ROWS), .COLS(COLS), .SETTLE(SETTLE)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (start_i),
      .skip_en_i (skip_en_i),
      .occ_i     (occ),
      .state_o   (state),
      .row_o     (row),
      .col_o     (col)
   );

   sparse_row_emit #(.COLS(COLS)) u_emit (
      .clk     (clk),
      .rst_n   (rst_n),
      .state_i (state),
      .col_i   (col),
      .act_i   (row_act_i[col]),
      .pol_i   (row_pol_i[col]),
      .word_o  (word_o),
      .wr_n_o  (wr_n_o),
      .eor_o   (eor_o),
      .eof_o   (eof_o)
   );

   assign row_sel_o = row;
   assign busy_o    = (state != RD_IDLE);

   AST_BUSY_AT_EOF: assert property (@(posedge clk) disable iff (!rst_n)
      eof_o |-> !busy_o); // R11
   AST_WORD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_n_o |-> $past(busy_o)); // R3

endmodule

// File: tb/sparse_row_readout_tb.sv
module sparse_row_readout_tb;
   localparam int ROWS = 64;
   localparam int COLS = 64;
   localparam int SETTLE = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic skip_en = 1'b0;
   logic [COLS-1:0] act_mem [ROWS];
   logic [COLS-1:0] pol_mem [ROWS];
   logic [5:0] row_sel;
   logic [6:0] word;
   logic wr_n, eor, eof, busy;

   int checks = 0;
   int fails = 0;
   logic [8:0] got_s [0:8191];
   logic [8:0] exp_s [0:8191];
   logic [8:0] ref_s [0:8191];
   int ng, ne, nref;

   always #10 clk = ~clk;

   sparse_row_readout #(.ROWS(ROWS), .COLS(COLS), .SETTLE(SETTLE)) u_dut (
      .clk(clk), .rst_n(rst_n), .start_i(start), .skip_en_i(skip_en),
      .row_act_i(act_mem[row_sel]), .row_pol_i(pol_mem[row_sel]),
      .row_sel_o(row_sel), .word_o(word), .wr_n_o(wr_n),
      .eor_o(eor), .eof_o(eof), .busy_o(busy)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int actv, input int expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, actv, expv);
      end
   endtask

   task automatic build_expected();
      ne = 0;
      for (int r = 0; r < ROWS; r++) begin
         for (int c = 0; c < COLS; c++) begin
            if (act_mem[r][c]) begin
               exp_s[ne] = {2'b00, pol_mem[r][c], 6'(c)};
               ne++;
            end
         end
         exp_s[ne] = 9'h100;
         ne++;
      end
      exp_s[ne] = 9'h180;
      ne++;
   endtask

   function automatic int frame_len(input bit skip);
      int s = 0;
      for (int r = 0; r < ROWS; r++)
         s += SETTLE + ((skip && act_mem[r] == '0) ? 1 : COLS);
      return s + 2;
   endfunction

   task automatic clear_frame();
      for (int r = 0; r < ROWS; r++) begin
         act_mem[r] = '0;
         pol_mem[r] = {$urandom, $urandom};
      end
   endtask

   task automatic run_frame(input bit skip, input bit toggle, input bit extra, input string tag);
      int cyc = 0;
      int eors = 0;
      int last_eor = -10;
      int eof_cyc = -1;
      int row_steps = 0;
      bit row_bad = 0;
      bit busy_bad = 0;
      int prev_row = 0;
      int first = 1;
      int mism = -1;
      build_expected();
      ng = 0;
      @(negedge clk);
      start = 1'b1;
      skip_en = skip;
      while (eof_cyc < 0 && cyc < 20000) begin
         @(posedge clk);
         cyc++;
         @(negedge clk);
         start = (extra && cyc == 100);
         if (toggle) skip_en = ~skip_en;
         if (first == 1) begin
            chk(row_sel == 6'd0, "R2", {tag, " first row index"}, row_sel, 0);
            first = 0;
         end else if (int'(row_sel) != prev_row) begin
            if (int'(row_sel) != prev_row + 1) row_bad = 1;
            row_steps++;
         end
         prev_row = row_sel;
         if (!wr_n) begin got_s[ng] = {2'b00, word}; ng++; end
         if (eor) begin got_s[ng] = 9'h100; ng++; eors++; last_eor = cyc; end
         if (eof) begin got_s[ng] = 9'h180; ng++; eof_cyc = cyc; end
         if (eof_cyc < 0 && !busy) busy_bad = 1;
         if (eof_cyc >= 0 && busy) busy_bad = 1;
      end
      start = 1'b0;
      skip_en = 1'b0;
      chk(eof_cyc >= 0, "R5", {tag, " eof reached"}, eof_cyc, 1);
      chk(eof_cyc == frame_len(skip), skip ? "R7" : "R6", {tag, " frame length"},
          eof_cyc, frame_len(skip));
      chk(eors == ROWS, "R4", {tag, " end-of-row count"}, eors, ROWS);
      chk(eof_cyc == last_eor + 1, "R5", {tag, " eof after last eor"}, eof_cyc, last_eor + 1);
      chk(!row_bad && row_steps == ROWS - 1, "R2", {tag, " row stepping"}, row_steps, ROWS - 1);
      chk(!busy_bad, "R11", {tag, " busy window"}, busy_bad, 0);
      for (int i = 0; i < ne; i++)
         if (mism < 0 && (i >= ng || got_s[i] != exp_s[i])) mism = i;
      if (mism < 0 && ng != ne) mism = ne;
      chk(mism < 0, "R3", {tag, " stream vs array (first bad index)"}, mism, -1);
      for (int k = 0; k < 6; k++) begin
         @(negedge clk);
         chk(!busy && !eof && wr_n && !eor, "R10", {tag, " quiet after frame"}, busy, 0);
      end
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk(wr_n == 1'b1 && !eor && !eof && !busy, "R1", "outputs in reset", {wr_n, eor, eof, busy}, 8);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk(wr_n == 1'b1 && !eor && !eof && !busy, "R1", "outputs after reset", {wr_n, eor, eof, busy}, 8);
      chk(row_sel == 6'd0, "R1", "row index after reset", row_sel, 0);
   endtask

   task automatic t_sparse_modes();
      for (int f = 0; f < 3; f++) begin
         clear_frame();
         for (int r = 0; r < ROWS; r++)
            if ($urandom % 3 == 0)
               for (int k = 0; k < 1 + int'($urandom % 4); k++)
                  act_mem[r][$urandom % COLS] = 1'b1;
         run_frame(1'b0, 1'b0, 1'b0, "sparse normal");
         nref = ng;
         for (int i = 0; i < ng; i++) ref_s[i] = got_s[i];
         run_frame(1'b1, 1'b0, 1'b0, "sparse skip");
         begin
            int bad = (nref != ng) ? 1 : 0;
            for (int i = 0; i < ng && i < nref; i++) if (ref_s[i] != got_s[i]) bad = 1;
            chk(bad == 0, "R8", "streams of both modes identical", ng, nref);
         end
      end
   endtask

   task automatic t_empty_frame();
      clear_frame();
      run_frame(1'b1, 1'b0, 1'b0, "empty skip R7");
      run_frame(1'b0, 1'b0, 1'b0, "empty normal R6");
   endtask

   task automatic t_edge_columns();
      clear_frame();
      act_mem[0] = '1;
      act_mem[1][63] = 1'b1;
      act_mem[5][0] = 1'b1;
      act_mem[63][0] = 1'b1;
      act_mem[63][63] = 1'b1;
      run_frame(1'b1, 1'b0, 1'b0, "edge columns skip R3");
      run_frame(1'b0, 1'b0, 1'b0, "edge columns normal R3");
   endtask

   task automatic t_mode_latched();
      clear_frame();
      act_mem[10][7] = 1'b1;
      act_mem[40][30] = 1'b1;
      run_frame(1'b1, 1'b1, 1'b0, "skip_en toggled mid-frame R9");
      run_frame(1'b0, 1'b1, 1'b0, "skip_en toggled normal R9");
   endtask

   task automatic t_start_ignored();
      clear_frame();
      act_mem[2][3] = 1'b1;
      act_mem[50][60] = 1'b1;
      run_frame(1'b1, 1'b0, 1'b1, "start during frame R10");
   endtask

   initial begin
      for (int r = 0; r < ROWS; r++) begin act_mem[r] = '0; pol_mem[r] = '0; end
      t_reset();
      t_sparse_modes();
      t_empty_frame();
      t_edge_columns();
      t_mode_latched();
      t_start_ignored();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog run did not finish actual=%0d expected=%0d", 190000, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule